// File: doc/BRIEF.md
# Low-Power Calibration Sleep Sequencer

This block lets a converter core sleep between background calibration runs. When low-power operation and background calibration are both enabled, it asks the core to sleep, wakes it, waits a settling interval so the core can stabilise, fires a one-cycle calibration start, and waits for the calibration engine to report completion before sending the core back to sleep.

The sleep interval is either timed (autonomous mode) or open-ended (trigger mode). In trigger mode the core is woken by a low level on the software trigger bit or on the external active-low trigger pin. Both the sleep and settle intervals are exponential codes of the form (2^k + 1) × 2^UNIT_LOG2 device clocks. A single down-counter times both intervals. An 8-bit configuration register holds the codes, the mode bit and the enable bit.

Top module: `lpcal_sleep_seq`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x48 and `sleep_req` and `cal_start` are low. The register layout is: bits [7:5] sleep code, bits [4:3] wake code, bit 1 trigger mode, bit 0 enable. Bit 2 always reads 0.
- R2: In autonomous mode (bit 1 = 0), `sleep_req` stays high for exactly (2^k + 1) << UNIT_LOG2 cycles. Here k = SLEEP_EXP[sleep code], and the defaults give k = 3, 15, 18, 21, 24, 27, 30, 33 for codes 0 to 7.
- R3: After every wake-up, the block waits exactly (2^k + 1) << UNIT_LOG2 cycles with `sleep_req` low before `cal_start`. Here k = WAKE_EXP[wake code], and the defaults give k = 3, 18, 21, 24 for codes 0 to 3.
- R4: `sleep_req` is never asserted unless both the enable bit and `bg_cal_en` are 1.
- R5: In autonomous mode, `soft_trig` and `ext_trig_n` have no effect on when the core wakes.
- R6: In trigger mode, the core sleeps with no time limit and the sleep code is ignored. The cycle after `soft_trig` or `ext_trig_n` is sampled low, `sleep_req` drops.
- R7: `cal_start` is a one-cycle pulse at the start of calibration. The block then waits for `cal_done`, and the cycle after `cal_done` is sampled high it raises `sleep_req` again.
- R8: When either enable is cleared, `sleep_req` is low from the next cycle on and any running interval is abandoned.
- R9: A configuration write made during a sleep or settle interval leaves that interval unchanged. It takes effect at the next interval load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration register contents |
| bg_cal_en | input | 1 | Background calibration enabled |
| soft_trig | input | 1 | Software trigger level (wakes the core when low in trigger mode) |
| ext_trig_n | input | 1 | External active-low trigger |
| cal_done | input | 1 | Calibration finished |
| sleep_req | output | 1 | Core sleep request |
| cal_start | output | 1 | One-cycle calibration start pulse |

## Verification
The bench builds the block with UNIT_LOG2 = 2, sleep exponents 1 to 8, wake exponents 0 to 3 and a 16-bit counter. With these values every code maps to an interval between 8 and 1028 cycles. Every sleep and wake code can then be timed to the exact cycle. The same values make back-to-back sleep loops, mid-interval configuration writes and trigger-mode wakes short enough to run many times. The default exponents are kept for elaboration, where they only change counter width and decode constants.

// File: rtl/lpcal_pkg.sv
package lpcal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_CAL    = 2'd3
  } lpcal_state_e;

  localparam int CFG_W        = 8;
  localparam int SLP_CODE_W   = 3;
  localparam int WAKE_CODE_W  = 2;
  localparam int EXP_W        = 6;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'h48;
  localparam logic [CFG_W-1:0] CFG_MASK  = 8'hFB;
endpackage

// File: rtl/lpcal_cfg_reg.sv
module lpcal_cfg_reg
  import lpcal_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [CFG_W-1:0]       wdata,
  output logic [CFG_W-1:0]       rdata,
  output logic [SLP_CODE_W-1:0]  sleep_code,
  output logic [WAKE_CODE_W-1:0] wake_code,
  output logic                   trig_mode,
  output logic                   lp_en
);
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = wdata & CFG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign rdata      = cfg_q;
  assign sleep_code = cfg_q[7:5];
  assign wake_code  = cfg_q[4:3];
  assign trig_mode  = cfg_q[1];
  assign lp_en      = cfg_q[0];

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[2] == 1'b0); // R1
endmodule

// File: rtl/lpcal_interval_dec.sv
module lpcal_interval_dec #(
  parameter int CODE_W    = 3,
  parameter int EXP_W     = 6,
  parameter int CNT_W     = 42,
  parameter int UNIT_LOG2 = 8,
  parameter int NUM       = 2**CODE_W,
  parameter logic [NUM-1:0][EXP_W-1:0] EXP_LIST = '0
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  interval
);
  logic [NUM-1:0][CNT_W-1:0] cand;

  for (genvar i = 0; i < NUM; i++) begin : g_cand
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] BASE = (ONE << EXP_LIST[i]) + ONE;
    assign cand[i] = BASE << UNIT_LOG2;
  end

  assign interval = cand[code];
endmodule

// File: rtl/lpcal_down_timer.sv
module lpcal_down_timer #(
  parameter int CNT_W = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)                 cnt_d = load_val - CNT_W'(1);
    else if (dec && !cnt_zero) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val) - CNT_W'(1)); // R2
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec && !cnt_zero) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R2
endmodule

// File: rtl/lpcal_sleep_seq.sv
module lpcal_sleep_seq
  import lpcal_pkg::*;
#(
  parameter int CNT_W     = 42,
  parameter int UNIT_LOG2 = 8,
  parameter logic [7:0][5:0] SLEEP_EXP = {6'd33, 6'd30, 6'd27, 6'd24, 6'd21, 6'd18, 6'd15, 6'd3},
  parameter logic [3:0][5:0] WAKE_EXP  = {6'd24, 6'd21, 6'd18, 6'd3}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       bg_cal_en,
  input  logic       soft_trig,
  input  logic       ext_trig_n,
  input  logic       cal_done,
  output logic       sleep_req,
  output logic       cal_start
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic [SLP_CODE_W-1:0]  sleep_code;
  logic [WAKE_CODE_W-1:0] wake_code;
  logic                   trig_mode;
  logic                   lp_en;

  lpcal_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .we         (cfg_we),
    .wdata      (cfg_wdata),
    .rdata      (cfg_rdata),
    .sleep_code (sleep_code),
    .wake_code  (wake_code),
    .trig_mode  (trig_mode),
    .lp_en      (lp_en)
  );

  logic [CNT_W-1:0] sleep_ival;
  logic [CNT_W-1:0] wake_ival;

  lpcal_interval_dec #(
    .CODE_W (SLP_CODE_W), .EXP_W (EXP_W), .CNT_W (CNT_W),
    .UNIT_LOG2 (UNIT_LOG2), .NUM (8), .EXP_LIST (SLEEP_EXP)
  ) u_sleep_dec (
    .code     (sleep_code),
    .interval (sleep_ival)
  );

  lpcal_interval_dec #(
    .CODE_W (WAKE_CODE_W), .EXP_W (EXP_W), .CNT_W (CNT_W),
    .UNIT_LOG2 (UNIT_LOG2), .NUM (4), .EXP_LIST (WAKE_EXP)
  ) u_wake_dec (
    .code     (wake_code),
    .interval (wake_ival)
  );

  lpcal_state_e     state_q, state_d;
  logic             mode_q, mode_d;
  logic             start_q, start_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_dec;
  logic             tmr_zero;
  logic             active;
  logic             wake_evt;

  assign active   = lp_en & bg_cal_en;
  assign wake_evt = ~soft_trig | ~ext_trig_n;

  lpcal_down_timer #(.CNT_W (CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .cnt_zero (tmr_zero)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    start_d  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = sleep_ival;
    tmr_dec  = 1'b0;
    if (!active) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d  = ST_SLEEP;
          tmr_load = 1'b1;
          mode_d   = trig_mode;
        end
        ST_SLEEP: begin
          if (mode_q ? wake_evt : tmr_zero) begin
            state_d  = ST_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = wake_ival;
          end else begin
            tmr_dec = ~mode_q;
          end
        end
        ST_SETTLE: begin
          if (tmr_zero) begin
            state_d = ST_CAL;
            start_d = 1'b1;
          end else begin
            tmr_dec = 1'b1;
          end
        end
        ST_CAL: begin
          if (cal_done) begin
            state_d  = ST_SLEEP;
            tmr_load = 1'b1;
            mode_d   = trig_mode;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      start_q <= start_d;
    end
  end

  assign sleep_req = (state_q == ST_SLEEP);
  assign cal_start = start_q;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    cal_start |=> !cal_start); // R7
  AST_START_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    cal_start |-> state_q == ST_CAL && $past(state_q) == ST_SETTLE); // R3
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(sleep_req) |-> $past(state_q) == ST_IDLE || $past(state_q) == ST_CAL); // R7
  AST_OFF_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    !active |=> !sleep_req); // R8
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (active && sleep_req && mode_q && soft_trig && ext_trig_n) |=> sleep_req); // R6
  AST_CAL_WAIT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (active && state_q == ST_CAL && !cal_done) |=> state_q == ST_CAL); // R7
endmodule

// File: tb/sim_lpcal_sleep_seq.sv
module sim_lpcal_sleep_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       bg_cal_en = 1'b0;
  logic       soft_trig = 1'b1;
  logic       ext_trig_n = 1'b1;
  logic       cal_done = 1'b0;
  logic       sleep_req;
  logic       cal_start;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  lpcal_sleep_seq #(
    .CNT_W (16), .UNIT_LOG2 (2),
    .SLEEP_EXP ({6'd8, 6'd7, 6'd6, 6'd5, 6'd4, 6'd3, 6'd2, 6'd1}),
    .WAKE_EXP  ({6'd3, 6'd2, 6'd1, 6'd0})
  ) u0 (
    .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata), .bg_cal_en (bg_cal_en), .soft_trig (soft_trig),
    .ext_trig_n (ext_trig_n), .cal_done (cal_done),
    .sleep_req (sleep_req), .cal_start (cal_start)
  );

  function automatic longint sleep_len(input int code);
    return ((longint'(1) << (code + 1)) + 1) * 4;
  endfunction
  function automatic longint wake_len(input int code);
    return ((longint'(1) << code) + 1) * 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // behavioural reference: 0 idle, 1 sleeping, 2 settling, 3 calibrating
  int     m_state;
  longint m_left;
  bit     m_trig;
  bit     m_start;
  logic [7:0] m_cfg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_left = 0; m_trig = 0; m_start = 0; m_cfg = 8'h48;
    end else begin
      m_start = 0;
      if (!(m_cfg[0] && bg_cal_en)) m_state = 0;
      else if (m_state == 0) begin
        m_state = 1; m_left = sleep_len(m_cfg[7:5]) - 1; m_trig = m_cfg[1];
      end else if (m_state == 1) begin
        if (m_trig ? (!soft_trig || !ext_trig_n) : (m_left == 0)) begin
          m_state = 2; m_left = wake_len(m_cfg[4:3]) - 1;
        end else if (m_left > 0) m_left--;
      end else if (m_state == 2) begin
        if (m_left == 0) begin m_state = 3; m_start = 1; end
        else m_left--;
      end else if (cal_done) begin
        m_state = 1; m_left = sleep_len(m_cfg[7:5]) - 1; m_trig = m_cfg[1];
      end
      if (cfg_we) m_cfg = cfg_wdata & 8'hFB;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(sleep_req == (m_state == 1), "R2 sleep_req vs model", sleep_req, m_state == 1);
      chk(cal_start == m_start, "R7 cal_start vs model", cal_start, m_start);
      chk(cfg_rdata == m_cfg, "R1 cfg_rdata vs model", cfg_rdata, m_cfg);
    end
  end

  // calibration engine stand-in: done three cycles after start
  initial begin
    forever begin
      @(negedge clk);
      if (cal_start) begin
        repeat (3) @(negedge clk);
        cal_done = 1'b1;
        @(negedge clk);
        cal_done = 1'b0;
      end
    end
  end

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic restart(input logic [7:0] v);
    write_cfg(8'h00);
    repeat (3) @(negedge clk);
    write_cfg(v);
  endtask

  // time one sleep and the following settle; optional write at sleep cycle 3
  task automatic measure(input bit do_wr, input logic [7:0] wv,
                         output longint sl, output longint st);
    sl = 0; st = 0;
    while (!sleep_req) @(negedge clk);
    while (sleep_req) begin
      sl++;
      if (do_wr && sl == 3) begin cfg_we = 1'b1; cfg_wdata = wv; end
      else cfg_we = 1'b0;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    while (!cal_start) begin st++; @(negedge clk); end
  endtask

  initial begin
    longint sl, st;
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 8'h48, "R1 reset cfg", cfg_rdata, 8'h48);
    chk(!sleep_req, "R1 reset sleep_req", sleep_req, 0);
    chk(!cal_start, "R1 reset cal_start", cal_start, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cmp_en = 1'b1;

    write_cfg(8'h4D);
    @(negedge clk);
    chk(cfg_rdata == 8'h49, "R1 reserved bit reads 0", cfg_rdata, 8'h49);

    // R4: enable set but background calibration off
    repeat (50) begin
      @(negedge clk);
      chk(!sleep_req, "R4 no sleep without bg_cal_en", sleep_req, 0);
    end
    bg_cal_en = 1'b1;

    restart(8'h01);
    measure(0, 8'h00, sl, st);
    chk(sl == sleep_len(0), "R2 sleep code 0", sl, sleep_len(0));
    chk(st == wake_len(0), "R3 wake code 0", st, wake_len(0));
    measure(0, 8'h00, sl, st);
    chk(sl == sleep_len(0), "R7 second loop sleep", sl, sleep_len(0));

    restart(8'h79);
    measure(0, 8'h00, sl, st);
    chk(sl == sleep_len(3), "R2 sleep code 3", sl, sleep_len(3));
    chk(st == wake_len(3), "R3 wake code 3", st, wake_len(3));

    restart(8'hE9);
    measure(0, 8'h00, sl, st);
    chk(sl == sleep_len(7), "R2 sleep code 7", sl, sleep_len(7));
    chk(st == wake_len(1), "R3 wake code 1", st, wake_len(1));

    // R9: write during sleep
    restart(8'h79);
    measure(1, 8'h01, sl, st);
    chk(sl == sleep_len(3), "R9 sleep unchanged by write", sl, sleep_len(3));
    chk(st == wake_len(0), "R9 settle uses new code", st, wake_len(0));
    measure(0, 8'h00, sl, st);
    chk(sl == sleep_len(0), "R9 next sleep uses new code", sl, sleep_len(0));

    // R5: triggers held low in autonomous mode
    restart(8'h01);
    ext_trig_n = 1'b0; soft_trig = 1'b0;
    measure(0, 8'h00, sl, st);
    chk(sl == sleep_len(0), "R5 triggers ignored", sl, sleep_len(0));
    ext_trig_n = 1'b1; soft_trig = 1'b1;

    // R6: trigger mode
    restart(8'h03);
    while (!sleep_req) @(negedge clk);
    repeat (100) @(negedge clk);
    chk(sleep_req, "R6 sleeps past sleep code", sleep_req, 1);
    ext_trig_n = 1'b0;
    @(negedge clk);
    ext_trig_n = 1'b1;
    chk(!sleep_req, "R6 wake by external trigger", sleep_req, 0);
    while (!sleep_req) @(negedge clk);
    repeat (50) @(negedge clk);
    chk(sleep_req, "R6 still asleep", sleep_req, 1);
    soft_trig = 1'b0;
    @(negedge clk);
    soft_trig = 1'b1;
    chk(!sleep_req, "R6 wake by software trigger", sleep_req, 0);

    // R8: disable mid-sleep
    restart(8'hE9);
    while (!sleep_req) @(negedge clk);
    repeat (20) @(negedge clk);
    bg_cal_en = 1'b0;
    @(negedge clk);
    chk(!sleep_req, "R8 disable drops sleep_req", sleep_req, 0);
    repeat (20) @(negedge clk);
    chk(!sleep_req, "R8 stays idle", sleep_req, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule